// File: doc/BRIEF.md
# Bit-Slice Register ALU

This block is one slice of a microprogrammed datapath. It holds a sixteen-word register file and a Q extension register. Each cycle it picks two operands, combines them in an eight-function ALU, and routes the result. The result can go to the data output, to the register file or to Q, either unshifted or shifted by one place. The slice width is a parameter between 2 and 16 bits. Slices of equal width can be chained through the carry pins and the serial shift pins.

A nine-bit microinstruction controls each cycle. It is split into three fields of three bits: source, function and destination. Two four-bit addresses select the register-file words. A direct data word, a carry-in and four serial shift inputs complete the operand set.

The flag outputs are group generate, group propagate, carry out, overflow, zero and MSB. A debug port loads or reads any register-file word, or Q, without a microinstruction. All state changes on the rising edge of the clock. An active-low asynchronous reset clears all state.

Top module: `bitslice_ralu`

## Requirements
- R1: The register file holds 16 words. Port A and port B read words at `a_addr_i` and `b_addr_i`. A rising edge writes the word at `b_addr_i` only for destination codes 2 to 7. Codes 0 and 1 leave every word unchanged, and the word at the A address is never written unless it equals the B address.
- R2: Operands come from the values held before the edge. When a cycle reads a word and writes the same word, its operand is the old value, and the new value is visible from the next cycle.
- R3: The source code picks the operand pair (R, S):
  - 0: (A, Q)
  - 1: (A, B)
  - 2: (0, Q)
  - 3: (0, B)
  - 4: (0, A)
  - 5: (D, A)
  - 6: (D, Q)
  - 7: (D, 0)
- R4: The function code picks the result F:
  - 0: R+S+cin
  - 1: S+~R+cin
  - 2: R+~S+cin
  - 3: R|S
  - 4: R&S
  - 5: ~R&S
  - 6: R^S
  - 7: ~(R^S)
- R5: Flags for arithmetic codes 0 to 2. Take X and Y as the adder operands after any inversion. `cout_o` is the carry out of X+Y+cin. `ovf_o` is two's-complement overflow of that sum. `cg_o` is the carry out of X+Y. `cp_o` is the AND of all bits of X|Y.
- R6: For logic codes 3 to 7, `cg_o`, `cp_o`, `cout_o` and `ovf_o` are 0. For every code, `zero_o` is set when F is zero, and `msb_o` is bit WIDTH-1 of F.
- R7: `y_o` is the A-port word for destination 2 and F for every other destination. When `oe_ni` is high, `y_o` is forced to zero.
- R8: Q loads F for destination 0. It shifts down for destination 4, taking `q_msb_i` into its MSB. It shifts up for destination 6, taking `q_lsb_i` into its LSB. It holds for every other destination.
- R9: The register-file write data is:
  - F for destinations 2 and 3.
  - F shifted down, with `ram_msb_i` entering the MSB, for destinations 4 and 5.
  - F shifted up, with `ram_lsb_i` entering the LSB, for destinations 6 and 7.
  
  The outputs `ram_lsb_o`, `ram_msb_o`, `q_lsb_o` and `q_msb_o` carry F[0], F[WIDTH-1], Q[0] and Q[WIDTH-1].
- R10: Driving `rst_ni` low clears all 16 words and Q at once, without waiting for a clock edge.
- R11: When `dbg_we_i` is high, an edge writes `dbg_wdata_i` to the target at `dbg_addr_i`. Addresses 0 to 15 select a register-file word and address 16 selects Q. Addresses 17 to 31 change nothing. In that cycle the microinstruction updates neither the register file nor Q.
- R12: `dbg_rdata_o` shows, with no clock delay, the word at `dbg_raddr_i` for addresses 0 to 15, Q for address 16, and zero for addresses 17 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 3 | Operand source code |
| fn_i | input | 3 | ALU function code |
| dst_i | input | 3 | Destination code |
| a_addr_i | input | 4 | Port A read address |
| b_addr_i | input | 4 | Port B read and write address |
| d_i | input | WIDTH | Direct data operand |
| cin_i | input | 1 | Carry in |
| ram_lsb_i | input | 1 | Serial bit entering the register-file LSB on an up shift |
| ram_msb_i | input | 1 | Serial bit entering the register-file MSB on a down shift |
| q_lsb_i | input | 1 | Serial bit entering the Q LSB on an up shift |
| q_msb_i | input | 1 | Serial bit entering the Q MSB on a down shift |
| oe_ni | input | 1 | Output enable, active low; high forces `y_o` to zero |
| dbg_we_i | input | 1 | Debug write strobe |
| dbg_addr_i | input | 5 | Debug write target (0-15 register file, 16 Q) |
| dbg_wdata_i | input | WIDTH | Debug write data |
| dbg_raddr_i | input | 5 | Debug read target |
| y_o | output | WIDTH | Data output |
| cg_o | output | 1 | Group carry generate |
| cp_o | output | 1 | Group carry propagate |
| cout_o | output | 1 | Carry out |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | F equals zero |
| msb_o | output | 1 | MSB of F |
| ram_lsb_o | output | 1 | F[0] |
| ram_msb_o | output | 1 | F[WIDTH-1] |
| q_lsb_o | output | 1 | Q[0] |
| q_msb_o | output | 1 | Q[WIDTH-1] |
| dbg_rdata_o | output | WIDTH | Debug read data |

## Verification
The bench builds the slice with WIDTH set to 6. This width is not a power of two, and it is small enough that random operands often hit the carry and overflow boundaries and an all-zero result. At six bits, random data quickly reaches all-ones words, sign-bit crossings, and shifts that move a serial input into both ends of a word. The debug address range 17 to 31 is reached often, and so is a write that collides with a read of the same word.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
  localparam int unsigned RF_DEPTH   = 16;
  localparam int unsigned RF_AW      = $clog2(RF_DEPTH);
  localparam int unsigned DBG_AW     = RF_AW + 1;
  localparam int unsigned Q_DBG_ADDR = RF_DEPTH;

  typedef enum logic [2:0] {
    SRC_AQ, SRC_AB, SRC_ZQ, SRC_ZB, SRC_ZA, SRC_DA, SRC_DQ, SRC_DZ
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_S_MINUS_R, FN_R_MINUS_S, FN_OR, FN_AND, FN_NOTR_AND, FN_XOR, FN_XNOR
  } fn_e;

  typedef enum logic [2:0] {
    DST_QLOAD, DST_PASS, DST_RF_YA, DST_RF, DST_RF_Q_DN, DST_RF_DN, DST_RF_Q_UP, DST_RF_UP
  } dst_e;
endpackage

// File: rtl/ralu_regfile.sv
module ralu_regfile
  import ralu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RF_AW-1:0] a_addr_i,
  input  logic [RF_AW-1:0] b_addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             dbg_we_i,
  input  logic [RF_AW-1:0] dbg_addr_i,
  input  logic [WIDTH-1:0] dbg_wdata_i,
  input  logic [RF_AW-1:0] dbg_raddr_i,
  output logic [WIDTH-1:0] a_rdata_o,
  output logic [WIDTH-1:0] b_rdata_o,
  output logic [WIDTH-1:0] dbg_rdata_o
);
  logic [RF_DEPTH-1:0][WIDTH-1:0] mem_q;

  for (genvar i = 0; i < RF_DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (dbg_we_i && dbg_addr_i == RF_AW'(i)) begin
        mem_q[i] <= dbg_wdata_i;
      end else if (we_i && b_addr_i == RF_AW'(i)) begin
        mem_q[i] <= wdata_i;
      end
    end
  end

  // Operands come from pre-edge contents, matching latches closed during the write phase.
  assign a_rdata_o   = mem_q[a_addr_i];
  assign b_rdata_o   = mem_q[b_addr_i];
  assign dbg_rdata_o = mem_q[dbg_raddr_i];

  AST_RF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !dbg_we_i) |=> $stable(mem_q)) else $error("rf changed without write"); // R1

  AST_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !dbg_we_i) |=> mem_q[$past(b_addr_i)] == $past(wdata_i)) else $error("rf write lost"); // R1
endmodule

// File: rtl/ralu_alu.sv
module ralu_alu
  import ralu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [2:0]       fn_i,
  input  logic [WIDTH-1:0] r_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             cg_o,
  output logic             cp_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             arith;
  logic [WIDTH:0]   sum, gsum;

  always_comb begin
    x     = r_i;
    y     = s_i;
    arith = 1'b0;
    unique case (fn_e'(fn_i))
      FN_ADD:       arith = 1'b1;
      FN_S_MINUS_R: begin arith = 1'b1; x = ~r_i; end
      FN_R_MINUS_S: begin arith = 1'b1; y = ~s_i; end
      default:      arith = 1'b0;
    endcase
  end

  assign sum  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin_i};
  assign gsum = {1'b0, x} + {1'b0, y};

  always_comb begin
    unique case (fn_e'(fn_i))
      FN_OR:       f_o = r_i | s_i;
      FN_AND:      f_o = r_i & s_i;
      FN_NOTR_AND: f_o = ~r_i & s_i;
      FN_XOR:      f_o = r_i ^ s_i;
      FN_XNOR:     f_o = ~(r_i ^ s_i);
      default:     f_o = sum[WIDTH-1:0];
    endcase
  end

  assign cout_o = arith & sum[WIDTH];
  assign ovf_o  = arith & (x[MSB] == y[MSB]) & (sum[MSB] != x[MSB]);
  assign cg_o   = arith & gsum[WIDTH];
  assign cp_o   = arith & (&(x | y));
endmodule

// File: rtl/ralu_dest.sv
module ralu_dest
  import ralu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [2:0]       dst_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             ram_lsb_i,
  input  logic             ram_msb_i,
  input  logic             q_lsb_i,
  input  logic             q_msb_i,
  output logic             rf_we_o,
  output logic [WIDTH-1:0] rf_wdata_o,
  output logic             q_we_o,
  output logic [WIDTH-1:0] q_wdata_o,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] f_dn, f_up, q_dn, q_up;

  assign f_dn = {ram_msb_i, f_i[WIDTH-1:1]};
  assign f_up = {f_i[WIDTH-2:0], ram_lsb_i};
  assign q_dn = {q_msb_i, q_i[WIDTH-1:1]};
  assign q_up = {q_i[WIDTH-2:0], q_lsb_i};

  always_comb begin
    rf_we_o    = 1'b1;
    rf_wdata_o = f_i;
    q_we_o     = 1'b0;
    q_wdata_o  = f_i;
    y_o        = f_i;
    unique case (dst_e'(dst_i))
      DST_QLOAD:   begin rf_we_o = 1'b0; q_we_o = 1'b1; end
      DST_PASS:    rf_we_o = 1'b0;
      DST_RF_YA:   y_o = a_i;
      DST_RF:      rf_wdata_o = f_i;
      DST_RF_Q_DN: begin rf_wdata_o = f_dn; q_we_o = 1'b1; q_wdata_o = q_dn; end
      DST_RF_DN:   rf_wdata_o = f_dn;
      DST_RF_Q_UP: begin rf_wdata_o = f_up; q_we_o = 1'b1; q_wdata_o = q_up; end
      default:     rf_wdata_o = f_up;
    endcase
  end
endmodule

// File: rtl/bitslice_ralu.sv
module bitslice_ralu
  import ralu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        src_i,
  input  logic [2:0]        fn_i,
  input  logic [2:0]        dst_i,
  input  logic [RF_AW-1:0]  a_addr_i,
  input  logic [RF_AW-1:0]  b_addr_i,
  input  logic [WIDTH-1:0]  d_i,
  input  logic              cin_i,
  input  logic              ram_lsb_i,
  input  logic              ram_msb_i,
  input  logic              q_lsb_i,
  input  logic              q_msb_i,
  input  logic              oe_ni,
  input  logic              dbg_we_i,
  input  logic [DBG_AW-1:0] dbg_addr_i,
  input  logic [WIDTH-1:0]  dbg_wdata_i,
  input  logic [DBG_AW-1:0] dbg_raddr_i,
  output logic [WIDTH-1:0]  y_o,
  output logic              cg_o,
  output logic              cp_o,
  output logic              cout_o,
  output logic              ovf_o,
  output logic              zero_o,
  output logic              msb_o,
  output logic              ram_lsb_o,
  output logic              ram_msb_o,
  output logic              q_lsb_o,
  output logic              q_msb_o,
  output logic [WIDTH-1:0]  dbg_rdata_o
);
  localparam logic [DBG_AW-1:0] QSEL = DBG_AW'(Q_DBG_ADDR);

  logic [WIDTH-1:0] a_word, b_word, q_q, r_op, s_op, alu_f;
  logic [WIDTH-1:0] rf_wdata, q_wdata, y_pre, rf_dbg_rdata;
  logic             rf_we, q_we, rf_dbg_we, q_dbg_we;

  assign rf_dbg_we = dbg_we_i & ~dbg_addr_i[DBG_AW-1];
  assign q_dbg_we  = dbg_we_i & (dbg_addr_i == QSEL);

  ralu_regfile #(.WIDTH(WIDTH)) regfile_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_addr_i    (a_addr_i),
    .b_addr_i    (b_addr_i),
    .we_i        (rf_we & ~dbg_we_i),
    .wdata_i     (rf_wdata),
    .dbg_we_i    (rf_dbg_we),
    .dbg_addr_i  (dbg_addr_i[RF_AW-1:0]),
    .dbg_wdata_i (dbg_wdata_i),
    .dbg_raddr_i (dbg_raddr_i[RF_AW-1:0]),
    .a_rdata_o   (a_word),
    .b_rdata_o   (b_word),
    .dbg_rdata_o (rf_dbg_rdata)
  );

  always_comb begin
    unique case (src_e'(src_i))
      SRC_AQ:  begin r_op = a_word; s_op = q_q;    end
      SRC_AB:  begin r_op = a_word; s_op = b_word; end
      SRC_ZQ:  begin r_op = '0;     s_op = q_q;    end
      SRC_ZB:  begin r_op = '0;     s_op = b_word; end
      SRC_ZA:  begin r_op = '0;     s_op = a_word; end
      SRC_DA:  begin r_op = d_i;    s_op = a_word; end
      SRC_DQ:  begin r_op = d_i;    s_op = q_q;    end
      default: begin r_op = d_i;    s_op = '0;     end
    endcase
  end

  ralu_alu #(.WIDTH(WIDTH)) alu_i (
    .fn_i   (fn_i),
    .r_i    (r_op),
    .s_i    (s_op),
    .cin_i  (cin_i),
    .f_o    (alu_f),
    .cout_o (cout_o),
    .ovf_o  (ovf_o),
    .cg_o   (cg_o),
    .cp_o   (cp_o)
  );

  ralu_dest #(.WIDTH(WIDTH)) dest_i (
    .dst_i      (dst_i),
    .f_i        (alu_f),
    .a_i        (a_word),
    .q_i        (q_q),
    .ram_lsb_i  (ram_lsb_i),
    .ram_msb_i  (ram_msb_i),
    .q_lsb_i    (q_lsb_i),
    .q_msb_i    (q_msb_i),
    .rf_we_o    (rf_we),
    .rf_wdata_o (rf_wdata),
    .q_we_o     (q_we),
    .q_wdata_o  (q_wdata),
    .y_o        (y_pre)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_q <= '0;
    else if (q_dbg_we)        q_q <= dbg_wdata_i;
    else if (q_we && !dbg_we_i) q_q <= q_wdata;
  end

  assign y_o       = oe_ni ? '0 : y_pre;
  assign zero_o    = (alu_f == '0);
  assign msb_o     = alu_f[WIDTH-1];
  assign ram_lsb_o = alu_f[0];
  assign ram_msb_o = alu_f[WIDTH-1];
  assign q_lsb_o   = q_q[0];
  assign q_msb_o   = q_q[WIDTH-1];

  always_comb begin
    if (!dbg_raddr_i[DBG_AW-1])  dbg_rdata_o = rf_dbg_rdata;
    else if (dbg_raddr_i == QSEL) dbg_rdata_o = q_q;
    else                          dbg_rdata_o = '0;
  end

  AST_CARRY_LOOKAHEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i < 3'd3) |-> (cout_o == (cg_o | (cp_o & cin_i)))) else $error("carry mismatch"); // R5

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i >= 3'd3) |-> !(cg_o | cp_o | cout_o | ovf_o)) else $error("logic flags"); // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 3'd2 && fn_i == 3'd4) |-> (alu_f == '0)) else $error("zero source"); // R3

  AST_Q_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_we_i && dst_i == 3'd0) |=> (q_q == $past(alu_f))) else $error("q load"); // R8

  AST_Q_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_we_i && dst_i != 3'd0 && dst_i != 3'd4 && dst_i != 3'd6) |=> $stable(q_q)) else $error("q hold"); // R8

  AST_DBG_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_we_i && dbg_addr_i > QSEL) |=> $stable(q_q)) else $error("dbg range"); // R11
endmodule

// File: tb/bitslice_ralu_tb_top.sv
module bitslice_ralu_tb_top;
  localparam int W = 6;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]   src, fn, dst;
  logic [3:0]   aa, ba;
  logic [W-1:0] d, dwd;
  logic         cin, rl, rm, ql, qm, oen, dwe;
  logic [4:0]   dad, drd;
  logic [W-1:0] y, drdata;
  logic         cg, cp, cout, ovf, zf, mf, rlo, rmo, qlo, qmo;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] m_rf [16];
  logic [W-1:0] m_q;

  bitslice_ralu #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .fn_i(fn), .dst_i(dst),
    .a_addr_i(aa), .b_addr_i(ba), .d_i(d), .cin_i(cin),
    .ram_lsb_i(rl), .ram_msb_i(rm), .q_lsb_i(ql), .q_msb_i(qm), .oe_ni(oen),
    .dbg_we_i(dwe), .dbg_addr_i(dad), .dbg_wdata_i(dwd), .dbg_raddr_i(drd),
    .y_o(y), .cg_o(cg), .cp_o(cp), .cout_o(cout), .ovf_o(ovf), .zero_o(zf),
    .msb_o(mf), .ram_lsb_o(rlo), .ram_msb_o(rmo), .q_lsb_o(qlo), .q_msb_o(qmo),
    .dbg_rdata_o(drdata)
  );

  task automatic chk(input string lbl, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", lbl, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dbg_model(input logic [4:0] a);
    if (a < 5'd16) return m_rf[a[3:0]];
    if (a == 5'd16) return m_q;
    return '0;
  endfunction

  // One microcycle: drive at negedge, check combinational outputs mid-low-phase, advance model.
  task automatic cyc(input string tag, input logic [2:0] s_, f_, t_, input logic [3:0] a_, b_,
                     input logic [W-1:0] d_, input logic c_, rl_, rm_, ql_, qm_, oe_,
                     input logic we_, input logic [4:0] da_, input logic [W-1:0] dw_,
                     input logic [4:0] dr_);
    logic [W-1:0] av, bv, r, s, x, yy, f, ey, rfw, qw;
    logic [W:0]   sm, gs;
    logic         ar;
    @(negedge clk);
    src = s_; fn = f_; dst = t_; aa = a_; ba = b_; d = d_; cin = c_;
    rl = rl_; rm = rm_; ql = ql_; qm = qm_; oen = oe_;
    dwe = we_; dad = da_; dwd = dw_; drd = dr_;
    #5;
    av = m_rf[a_]; bv = m_rf[b_];
    case (s_)
      3'd0: begin r = av; s = m_q; end
      3'd1: begin r = av; s = bv; end
      3'd2: begin r = '0; s = m_q; end
      3'd3: begin r = '0; s = bv; end
      3'd4: begin r = '0; s = av; end
      3'd5: begin r = d_; s = av; end
      3'd6: begin r = d_; s = m_q; end
      default: begin r = d_; s = '0; end
    endcase
    ar = (f_ < 3'd3);
    x = (f_ == 3'd1) ? ~r : r;
    yy = (f_ == 3'd2) ? ~s : s;
    sm = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, c_};
    gs = {1'b0, x} + {1'b0, yy};
    case (f_)
      3'd3: f = r | s;
      3'd4: f = r & s;
      3'd5: f = ~r & s;
      3'd6: f = r ^ s;
      3'd7: f = ~(r ^ s);
      default: f = sm[W-1:0];
    endcase
    ey = oe_ ? '0 : ((t_ == 3'd2) ? av : f);
    chk({tag, " R7 y"}, int'(y), int'(ey));
    chk({tag, " R5 cout"}, int'(cout), ar ? int'(sm[W]) : 0);
    chk({tag, " R5 ovf"}, int'(ovf), ar ? int'((x[W-1] == yy[W-1]) && (f[W-1] != x[W-1])) : 0);
    chk({tag, " R5 cg"}, int'(cg), ar ? int'(gs[W]) : 0);
    chk({tag, " R5 cp"}, int'(cp), ar ? int'(&(x | yy)) : 0);
    chk({tag, " R6 zero"}, int'(zf), int'(f == '0));
    chk({tag, " R6 msb"}, int'(mf), int'(f[W-1]));
    chk({tag, " R9 shift outs"}, int'({rlo, rmo, qlo, qmo}),
        int'({f[0], f[W-1], m_q[0], m_q[W-1]}));
    chk({tag, " R12 dbg read"}, int'(drdata), int'(dbg_model(dr_)));
    // advance model
    if (we_) begin
      if (da_ < 5'd16) m_rf[da_[3:0]] = dw_;
      else if (da_ == 5'd16) m_q = dw_;
    end else begin
      case (t_)
        3'd4, 3'd5: rfw = {rm_, f[W-1:1]};
        3'd6, 3'd7: rfw = {f[W-2:0], rl_};
        default:    rfw = f;
      endcase
      if (t_ >= 3'd2) m_rf[b_] = rfw;
      qw = m_q;
      if (t_ == 3'd0) qw = f;
      else if (t_ == 3'd4) qw = {qm_, m_q[W-1:1]};
      else if (t_ == 3'd6) qw = {m_q[W-2:0], ql_};
      m_q = qw;
    end
  endtask

  task automatic dbg_wr(input string tag, input logic [4:0] a, input logic [W-1:0] v);
    cyc(tag, 3'd0, 3'd0, 3'd1, 4'd0, 4'd0, '0, 0, 0, 0, 0, 0, 0, 1'b1, a, v, a);
  endtask

  task automatic idle_rd(input string tag, input logic [4:0] a);
    cyc(tag, 3'd1, 3'd0, 3'd1, 4'd0, 4'd0, '0, 0, 0, 0, 0, 0, 0, 1'b0, 5'd0, '0, a);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    src = 0; fn = 0; dst = 3'd1; aa = 0; ba = 0; d = 0; cin = 0;
    rl = 0; rm = 0; ql = 0; qm = 0; oen = 0; dwe = 0; dad = 0; dwd = 0; drd = 0;
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_q = '0;
    repeat (3) @(posedge clk);
    // R10: reset state, all 17 debug locations read zero
    for (int i = 0; i < 17; i++) begin
      drd = 5'(i); #1;
      chk("R10 reset state", int'(drdata), 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: write lands at B address only, A word untouched
    dbg_wr("R11 preload", 5'd5, 6'd42);
    dbg_wr("R11 preload", 5'd9, 6'd7);
    cyc("R1 write B", 3'd4, 3'd0, 3'd3, 4'd5, 4'd9, '0, 0, 0, 0, 0, 0, 0, 0, 0, '0, 5'd5);
    idle_rd("R1 A untouched", 5'd5);
    idle_rd("R1 B written", 5'd9);
    // R2: same word read and written, old operand used
    dbg_wr("R2 preload", 5'd3, 6'd5);
    cyc("R2 read old", 3'd1, 3'd0, 3'd3, 4'd3, 4'd3, '0, 0, 0, 0, 0, 0, 0, 0, 0, '0, 5'd3);
    idle_rd("R2 new value", 5'd3);
    // R3/R4: D-only source, R minus S with carry-in, then S minus R
    cyc("R3 D0 source", 3'd7, 3'd3, 3'd1, 4'd0, 4'd0, 6'd33, 0, 0, 0, 0, 0, 0, 0, 0, '0, 5'd0);
    cyc("R4 R minus S", 3'd5, 3'd2, 3'd1, 4'd5, 4'd0, 6'd3, 1, 0, 0, 0, 0, 0, 0, 0, '0, 5'd0);
    cyc("R4 S minus R", 3'd5, 3'd1, 3'd1, 4'd5, 4'd0, 6'd3, 1, 0, 0, 0, 0, 0, 0, 0, '0, 5'd0);
    // R5: all-ones plus one carries out; max positive plus one overflows
    cyc("R5 carry", 3'd7, 3'd0, 3'd1, 4'd0, 4'd0, ONES, 1, 0, 0, 0, 0, 0, 0, 0, '0, 5'd0);
    cyc("R5 overflow", 3'd7, 3'd0, 3'd1, 4'd0, 4'd0, 6'd31, 1, 0, 0, 0, 0, 0, 0, 0, '0, 5'd0);
    // R7: A word on y, then output disable
    cyc("R7 y=A", 3'd7, 3'd0, 3'd2, 4'd5, 4'd12, 6'd1, 0, 0, 0, 0, 0, 0, 0, 0, '0, 5'd12);
    cyc("R7 oe off", 3'd7, 3'd0, 3'd1, 4'd0, 4'd0, 6'd9, 0, 0, 0, 0, 0, 1, 0, 0, '0, 5'd0);
    // R8/R9: load Q, shift both down then up with serial inputs set
    cyc("R8 q load", 3'd7, 3'd0, 3'd0, 4'd0, 4'd0, 6'd37, 0, 0, 0, 0, 0, 0, 0, 0, '0, 5'd16);
    cyc("R8 q down", 3'd7, 3'd0, 3'd4, 4'd0, 4'd2, 6'd37, 0, 0, 1, 0, 1, 0, 0, 0, '0, 5'd16);
    idle_rd("R9 rf down", 5'd2);
    cyc("R8 q up", 3'd7, 3'd0, 3'd6, 4'd0, 4'd2, 6'd37, 0, 1, 0, 1, 0, 0, 0, 0, '0, 5'd16);
    idle_rd("R9 rf up", 5'd2);
    idle_rd("R8 q after up", 5'd16);
    // R11: out-of-range debug write changes nothing and blocks the microinstruction
    cyc("R11 ignored", 3'd7, 3'd0, 3'd0, 4'd0, 4'd7, 6'd11, 0, 0, 0, 0, 0, 0, 1, 5'd23, 6'd63, 5'd16);
    for (int i = 0; i < 17; i++) idle_rd("R11 no change", 5'(i));
    idle_rd("R12 high addr", 5'd30);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      cyc("rand", 3'($urandom), 3'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
          W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom % 8) == 0, ($urandom % 8) == 0, 5'($urandom), W'($urandom), 5'($urandom));
    end

    // R10: asynchronous reset mid-run
    @(negedge clk); dwe = 0; #3; rst_n = 1'b0; #1;
    for (int i = 0; i < 17; i++) begin
      drd = 5'(i); #1;
      chk("R10 async clear", int'(drdata), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule